// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Controller

This block steers instruction fetch for one warp whose threads may take different sides of a branch. Every cycle it is told how the instruction at the current fetch address resolved. If no branch resolved, it moves to the next sequential address. If a branch resolved, it gets a per-thread taken mask, the taken target, the fall-through address and the branch's reconvergence address (the immediate post-dominator, worked out by the compiler). It then registers the next fetch address and the set of threads that are active for it.

When the active threads disagree about a branch, the taken side runs first. The fall-through side, its threads and the join address are saved on a hardware stack. Control moves to the saved side, and later back to the joined warp, when the address about to be fetched equals the join address in the top stack entry. No explicit push or pop command is needed. Nested splits stack on top of one another. A push to a full stack, and a split whose taken target is already the pending join address, each set a sticky error flag.

Top module: `simt_reconv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack is emptied, `fetch_pc` loads `start_pc`, every bit of `active_mask` becomes 1, and both error flags clear.
- R2: In a cycle with `br_valid` low and no join match, the next `fetch_pc` is the current one plus 4, and `active_mask` is unchanged.
- R3: A branch is uniform when `br_taken & active_mask` is either all the active bits or zero. Bits of `br_taken` for inactive threads are ignored. A uniform branch goes to `br_target` (all taken) or to `br_fallthru` (none taken). It keeps the mask and pushes nothing, even though `br_reconv` is valid.
- R4: A divergent branch goes to `br_target` with `active_mask` set to the taken active threads. It pushes the fall-through address, the join address, the not-taken active threads and the pre-split mask.
- R5: When the computed next address equals the top entry's join address and that entry is in its first phase, fetch goes to the saved fall-through address instead, with only the saved not-taken threads active. The entry moves to its second phase.
- R6: When the computed next address equals the top entry's join address and that entry is in its second phase, fetch continues at the join address with the pre-split mask restored, and the entry is popped.
- R7: A divergent branch inside a divergent path pushes a new entry above the outer one. After the inner join, the outer entry's fall-through address and mask are still intact.
- R8: The join comparison applies to every computed next address, whether it comes from sequential advance (plus 4) or from a uniform branch.
- R9: A divergent branch while the stack holds `DEPTH` entries sets `ovf_err`, which stays set until reset. The stack is left unchanged and fetch still follows the taken path with the taken mask.
- R10: A divergent branch whose `br_target` equals the top entry's join address sets `clash_err`, which stays set until reset. The push still happens and fetch goes to `br_target` with the taken mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pc | input | PC_W | Fetch address loaded at reset |
| br_valid | input | 1 | The instruction at `fetch_pc` is a resolved branch |
| br_taken | input | LANES | Per-thread taken outcome |
| br_target | input | PC_W | Taken target address |
| br_fallthru | input | PC_W | Not-taken continuation address |
| br_reconv | input | PC_W | Join address of the branch |
| fetch_pc | output | PC_W | Current fetch address |
| active_mask | output | LANES | Threads enabled for `fetch_pc` |
| ovf_err | output | 1 | Sticky: a push was refused on a full stack |
| clash_err | output | 1 | Sticky: a split targeted the pending join address |

## Verification
The bench checks that the second side of an if-else is reached by falling into the join address with plus 4, and also by a uniform jump to it. A design that compared only one of these sources would run past the join with the wrong threads. In the nested test the inner and outer joins are unwound in turn, and the outer fall-through side is checked after the inner pop. An implementation that overwrote or lost the outer entry would resume at the wrong address or with the wrong mask. Two more cases are covered. Taken bits set for inactive threads must not turn a uniform branch into a split. An all-taken branch that carries a valid join address must push nothing, which is shown by a later fetch of that address passing straight through. Stack overflow and the split-onto-join clash are driven to check that each sticky flag rises and that the stack contents survive.

// File: rtl/simt_reconv_pkg.sv
// Package: shared step actions and constants for the divergence controller.
// Assumes instructions are a fixed 4 bytes apart.
package simt_reconv_pkg;

    // Decision taken for one fetch step.
    typedef enum logic [2:0] {
        ACT_SEQ     = 3'd0,  // sequential advance
        ACT_UNIFORM = 3'd1,  // branch with all active threads agreeing
        ACT_SPLIT   = 3'd2,  // divergent branch, taken side first
        ACT_TO_ALT  = 3'd3,  // join reached on first side, switch sides
        ACT_JOIN    = 3'd4   // join reached on second side, restore warp
    } step_act_e;

    localparam int PC_STEP = 4;

endpackage

// File: rtl/simt_path_stack.sv
// Module: simt_path_stack
// Holds one entry per open divergent branch: the saved side's start
// address, the join address, the saved side's mask, the pre-split mask
// and a phase bit. Assumes the caller never pushes when full, never pops
// when empty, and never pushes and pops in the same cycle.
module simt_path_stack #(
    parameter int DEPTH = 8,
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             phase_set_i,
    input  logic [PC_W-1:0]  push_alt_pc_i,
    input  logic [PC_W-1:0]  push_rpc_i,
    input  logic [LANES-1:0] push_alt_mask_i,
    input  logic [LANES-1:0] push_pre_mask_i,
    output logic             empty_o,
    output logic             full_o,
    output logic [PC_W-1:0]  top_alt_pc_o,
    output logic [PC_W-1:0]  top_rpc_o,
    output logic [LANES-1:0] top_alt_mask_o,
    output logic [LANES-1:0] top_pre_mask_o,
    output logic             top_phase_o
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0]  sp;
    logic [IDX_W-1:0] top_idx;
    logic [PC_W-1:0]  alt_pc_q   [DEPTH];
    logic [PC_W-1:0]  rpc_q      [DEPTH];
    logic [LANES-1:0] alt_mask_q [DEPTH];
    logic [LANES-1:0] pre_mask_q [DEPTH];
    logic [DEPTH-1:0] phase_q;

    assign empty_o = (sp == '0);
    assign full_o  = (sp == SP_W'(DEPTH));
    assign top_idx = IDX_W'(sp - SP_W'(1));

    // Present the top entry to the step controller.
    always_comb begin
        top_alt_pc_o   = alt_pc_q[top_idx];
        top_rpc_o      = rpc_q[top_idx];
        top_alt_mask_o = alt_mask_q[top_idx];
        top_pre_mask_o = pre_mask_q[top_idx];
        top_phase_o    = phase_q[top_idx];
    end

    // Move the stack pointer on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push_i && !full_o) begin
            sp <= sp + SP_W'(1);
        end else if (pop_i && !empty_o) begin
            sp <= sp - SP_W'(1);
        end
    end

    // One storage slot per stack level.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture a new entry into this slot when it is the next free one.
        always_ff @(posedge clk) begin
            if (push_i && !full_o && (sp == SP_W'(g))) begin
                alt_pc_q[g]   <= push_alt_pc_i;
                rpc_q[g]      <= push_rpc_i;
                alt_mask_q[g] <= push_alt_mask_i;
                pre_mask_q[g] <= push_pre_mask_i;
            end
        end

        // Track which side of the split this slot is on.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase_q[g] <= 1'b0;
            end else if (push_i && !full_o && (sp == SP_W'(g))) begin
                phase_q[g] <= 1'b0;
            end else if (phase_set_i && !empty_o && (top_idx == IDX_W'(g))) begin
                phase_q[g] <= 1'b1;
            end
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    // R7
    depth_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (sp == $past(sp) + SP_W'(1)));

    // R5
    phase_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_set_i |-> (!empty_o && !top_phase_o));

endmodule

// File: rtl/simt_step_ctrl.sv
// Module: simt_step_ctrl
// Combinational decision for one fetch step: detects divergence among the
// active threads, forms the candidate next address and compares it with
// the join address of the top stack entry. Assumes cur_mask is never zero.
module simt_step_ctrl
    import simt_reconv_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32
) (
    input  logic [PC_W-1:0]  cur_pc_i,
    input  logic [LANES-1:0] cur_mask_i,
    input  logic             br_valid_i,
    input  logic [LANES-1:0] br_taken_i,
    input  logic [PC_W-1:0]  br_target_i,
    input  logic [PC_W-1:0]  br_fallthru_i,
    input  logic             stk_empty_i,
    input  logic             stk_full_i,
    input  logic [PC_W-1:0]  top_alt_pc_i,
    input  logic [PC_W-1:0]  top_rpc_i,
    input  logic [LANES-1:0] top_alt_mask_i,
    input  logic [LANES-1:0] top_pre_mask_i,
    input  logic             top_phase_i,
    output step_act_e        act_o,
    output logic [PC_W-1:0]  nxt_pc_o,
    output logic [LANES-1:0] nxt_mask_o,
    output logic             push_o,
    output logic             pop_o,
    output logic             phase_set_o,
    output logic [LANES-1:0] split_rest_o,
    output logic             ovf_evt_o,
    output logic             clash_evt_o
);

    logic [LANES-1:0] taken_act;
    logic [LANES-1:0] rest_act;
    logic             split;
    logic [PC_W-1:0]  seq_pc;
    logic             join_hit;

    // Separate the active threads by branch outcome.
    always_comb begin
        taken_act = br_taken_i & cur_mask_i;
        rest_act  = cur_mask_i & ~br_taken_i;
        split     = br_valid_i && (|taken_act) && (|rest_act);
    end

    // Candidate next address when the warp stays together.
    always_comb begin
        if (!br_valid_i) begin
            seq_pc = cur_pc_i + PC_W'(PC_STEP);
        end else if (|taken_act) begin
            seq_pc = br_target_i;
        end else begin
            seq_pc = br_fallthru_i;
        end
        join_hit = !stk_empty_i && (seq_pc == top_rpc_i);
    end

    // Pick the step action and its next address and mask.
    always_comb begin
        act_o        = ACT_SEQ;
        nxt_pc_o     = seq_pc;
        nxt_mask_o   = cur_mask_i;
        push_o       = 1'b0;
        pop_o        = 1'b0;
        phase_set_o  = 1'b0;
        ovf_evt_o    = 1'b0;
        clash_evt_o  = 1'b0;
        split_rest_o = rest_act;
        if (split) begin
            act_o       = ACT_SPLIT;
            nxt_pc_o    = br_target_i;
            nxt_mask_o  = taken_act;
            push_o      = !stk_full_i;
            ovf_evt_o   = stk_full_i;
            clash_evt_o = !stk_empty_i && (br_target_i == top_rpc_i);
        end else if (join_hit && !top_phase_i) begin
            act_o       = ACT_TO_ALT;
            nxt_pc_o    = top_alt_pc_i;
            nxt_mask_o  = top_alt_mask_i;
            phase_set_o = 1'b1;
        end else if (join_hit) begin
            act_o      = ACT_JOIN;
            nxt_pc_o   = top_rpc_i;
            nxt_mask_o = top_pre_mask_i;
            pop_o      = 1'b1;
        end else if (br_valid_i) begin
            act_o = ACT_UNIFORM;
        end
    end

endmodule

// File: rtl/simt_reconv_unit.sv
// Module: simt_reconv_unit (top)
// Per-warp fetch address and active mask sequencer with a reconvergence
// stack. Assumes the branch inputs describe the instruction at fetch_pc
// in the same cycle, and that nested branches use distinct join addresses.
module simt_reconv_unit
    import simt_reconv_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] active_mask,
    output logic             ovf_err,
    output logic             clash_err
);

    step_act_e        act;
    logic [PC_W-1:0]  nxt_pc;
    logic [LANES-1:0] nxt_mask;
    logic             push, pop, phase_set, ovf_evt, clash_evt;
    logic [LANES-1:0] split_rest;
    logic             stk_empty, stk_full, top_phase;
    logic [PC_W-1:0]  top_alt_pc, top_rpc;
    logic [LANES-1:0] top_alt_mask, top_pre_mask;

    simt_step_ctrl #(.LANES(LANES), .PC_W(PC_W)) u_ctrl (
        .cur_pc_i       (fetch_pc),
        .cur_mask_i     (active_mask),
        .br_valid_i     (br_valid),
        .br_taken_i     (br_taken),
        .br_target_i    (br_target),
        .br_fallthru_i  (br_fallthru),
        .stk_empty_i    (stk_empty),
        .stk_full_i     (stk_full),
        .top_alt_pc_i   (top_alt_pc),
        .top_rpc_i      (top_rpc),
        .top_alt_mask_i (top_alt_mask),
        .top_pre_mask_i (top_pre_mask),
        .top_phase_i    (top_phase),
        .act_o          (act),
        .nxt_pc_o       (nxt_pc),
        .nxt_mask_o     (nxt_mask),
        .push_o         (push),
        .pop_o          (pop),
        .phase_set_o    (phase_set),
        .split_rest_o   (split_rest),
        .ovf_evt_o      (ovf_evt),
        .clash_evt_o    (clash_evt)
    );

    simt_path_stack #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W)) u_stack (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_i          (push),
        .pop_i           (pop),
        .phase_set_i     (phase_set),
        .push_alt_pc_i   (br_fallthru),
        .push_rpc_i      (br_reconv),
        .push_alt_mask_i (split_rest),
        .push_pre_mask_i (active_mask),
        .empty_o         (stk_empty),
        .full_o          (stk_full),
        .top_alt_pc_o    (top_alt_pc),
        .top_rpc_o       (top_rpc),
        .top_alt_mask_o  (top_alt_mask),
        .top_pre_mask_o  (top_pre_mask),
        .top_phase_o     (top_phase)
    );

    // Register the fetch address and active mask for the next step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc    <= start_pc;
            active_mask <= '1;
        end else begin
            fetch_pc    <= nxt_pc;
            active_mask <= nxt_mask;
        end
    end

    // Keep the error flags set once raised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_err   <= 1'b0;
            clash_err <= 1'b0;
        end else begin
            ovf_err   <= ovf_err | ovf_evt;
            clash_err <= clash_err | clash_evt;
        end
    end

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SEQ) |=> (fetch_pc == $past(fetch_pc) + PC_W'(PC_STEP))
                             && (active_mask == $past(active_mask)));

    // R4
    split_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SPLIT) |=> ((active_mask & ~$past(active_mask)) == '0)
                               && (active_mask != $past(active_mask)));

    // R6
    join_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_JOIN) |=> (fetch_pc == $past(top_rpc)));

    // R5
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R10
    clash_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash_err |=> clash_err);

endmodule

// File: tb/simt_reconv_unit_tb.sv
`timescale 1ns/1ps
module simt_reconv_unit_tb;

    localparam int LANES = 8;
    localparam int PC_W  = 32;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  start_pc = 32'h100;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_taken = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic [PC_W-1:0]  br_fallthru = '0;
    logic [PC_W-1:0]  br_reconv = '0;
    logic [PC_W-1:0]  fetch_pc;
    logic [LANES-1:0] active_mask;
    logic             ovf_err, clash_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simt_reconv_unit #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .fetch_pc(fetch_pc), .active_mask(active_mask),
        .ovf_err(ovf_err), .clash_err(clash_err)
    );

    // Compare address and mask against expected values.
    task automatic expect_state(input logic [PC_W-1:0] epc, input logic [LANES-1:0] emask,
                                input string req);
        total++;
        if (fetch_pc !== epc || active_mask !== emask) begin
            bad++;
            $display("FAIL %s: pc=%h mask=%b expected pc=%h mask=%b",
                     req, fetch_pc, active_mask, epc, emask);
        end
    endtask

    // Compare the sticky flags against expected values.
    task automatic expect_flags(input logic eovf, input logic eclash, input string req);
        total++;
        if (ovf_err !== eovf || clash_err !== eclash) begin
            bad++;
            $display("FAIL %s: ovf=%b clash=%b expected ovf=%b clash=%b",
                     req, ovf_err, clash_err, eovf, eclash);
        end
    endtask

    // Apply a synchronous reset with a given start address.
    task automatic do_reset(input logic [PC_W-1:0] spc);
        @(negedge clk);
        rst_n = 1'b0; start_pc = spc; br_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_state(spc, 8'hFF, "R1");
        expect_flags(1'b0, 1'b0, "R1");
    endtask

    // One step without a branch.
    task automatic seq_step;
        br_valid = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    // One step with a resolved branch.
    task automatic br_step(input logic [LANES-1:0] tk, input logic [PC_W-1:0] tgt,
                           input logic [PC_W-1:0] ft, input logic [PC_W-1:0] rc);
        br_valid = 1'b1; br_taken = tk; br_target = tgt; br_fallthru = ft; br_reconv = rc;
        @(posedge clk); @(negedge clk);
        br_valid = 1'b0;
    endtask

    // Two-sided if-else with joins from a uniform jump and from plus 4.
    task automatic test_if_else;
        do_reset(32'h100);
        seq_step();                                   expect_state(32'h104, 8'hFF, "R2");
        br_step(8'h0F, 32'h200, 32'h2F8, 32'h300);   expect_state(32'h200, 8'h0F, "R4");
        seq_step();                                   expect_state(32'h204, 8'h0F, "R2");
        br_step(8'hFF, 32'h300, 32'h208, 32'h0);     expect_state(32'h2F8, 8'hF0, "R5 R8 uniform");
        seq_step();                                   expect_state(32'h2FC, 8'hF0, "R2");
        seq_step();                                   expect_state(32'h300, 8'hFF, "R6 R8 seq");
        seq_step();                                   expect_state(32'h304, 8'hFF, "R6 popped");
        expect_flags(1'b0, 1'b0, "R6");
    endtask

    // Nested if-else inside the taken side.
    task automatic test_nested;
        do_reset(32'h100);
        br_step(8'h3C, 32'h400, 32'h500, 32'h600);   expect_state(32'h400, 8'h3C, "R4");
        br_step(8'h8D, 32'h440, 32'h480, 32'h4C0);   expect_state(32'h440, 8'h0C, "R7 R3 inactive bits");
        br_step(8'hFF, 32'h4C0, 32'h444, 32'h0);     expect_state(32'h480, 8'h30, "R7 inner alt");
        br_step(8'hFF, 32'h4C0, 32'h484, 32'h0);     expect_state(32'h4C0, 8'h3C, "R7 inner join");
        br_step(8'hFF, 32'h600, 32'h4C4, 32'h0);     expect_state(32'h500, 8'hC3, "R7 outer alt");
        br_step(8'h00, 32'h999, 32'h600, 32'h0);     expect_state(32'h600, 8'hFF, "R7 outer join");
        seq_step();                                   expect_state(32'h604, 8'hFF, "R7");
        expect_flags(1'b0, 1'b0, "R7");
    endtask

    // Uniform branches push nothing even with a valid join address.
    task automatic test_uniform;
        do_reset(32'h100);
        br_step(8'hFF, 32'h800, 32'h104, 32'h900);   expect_state(32'h800, 8'hFF, "R3 all taken");
        br_step(8'h00, 32'h123, 32'h900, 32'hAAA);   expect_state(32'h900, 8'hFF, "R3 none taken");
        seq_step();                                   expect_state(32'h904, 8'hFF, "R3");
    endtask

    // Fill the stack, overflow it, then show the top entry survived.
    task automatic test_overflow;
        do_reset(32'h100);
        br_step(8'h7F, 32'h1000, 32'h1800, 32'h1C00); expect_state(32'h1000, 8'h7F, "R4");
        br_step(8'h3F, 32'h2000, 32'h2800, 32'h2C00); expect_state(32'h2000, 8'h3F, "R4");
        br_step(8'h1F, 32'h3000, 32'h3800, 32'h3C00); expect_state(32'h3000, 8'h1F, "R4");
        br_step(8'h0F, 32'h4000, 32'h4800, 32'h4C00); expect_state(32'h4000, 8'h0F, "R4");
        expect_flags(1'b0, 1'b0, "R9 full not yet over");
        br_step(8'h07, 32'h5000, 32'h5800, 32'h5C00); expect_state(32'h5000, 8'h07, "R9");
        expect_flags(1'b1, 1'b0, "R9");
        br_step(8'hFF, 32'h4C00, 32'h5004, 32'h0);   expect_state(32'h4800, 8'h10, "R9 top kept");
        seq_step();
        expect_flags(1'b1, 1'b0, "R9 sticky");
    endtask

    // Split whose target equals the pending join address.
    task automatic test_clash;
        do_reset(32'h100);
        br_step(8'h0F, 32'h200, 32'h300, 32'h400);   expect_state(32'h200, 8'h0F, "R4");
        br_step(8'h03, 32'h400, 32'h220, 32'h240);   expect_state(32'h400, 8'h03, "R10");
        expect_flags(1'b0, 1'b1, "R10");
        seq_step();
        expect_flags(1'b0, 1'b1, "R10 sticky");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++;
                total++;
                $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        test_if_else();
        test_nested();
        test_uniform();
        test_overflow();
        test_clash();
        do_reset(32'h40);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule